// File: doc/BRIEF.md
# Port Change Interrupt Detector

This block watches ten general-purpose input pins: six on port A (bits 5 down to 0) and the upper four pins of port B (bits 7 down to 4). Each pin first passes through a synchronizer. The block then compares each pin with a reference copy that it holds. When a pin that software has enabled differs from its reference, the block raises a sticky change flag. A separate interrupt-enable input gates that flag onto the request line sent to the interrupt controller.

The reference copy changes only when software reads the ports. A port-read strobe loads the current synchronized pin values into the reference, and the same values appear on the data outputs. While a mismatch remains, the flag keeps setting itself again, so a clear has no effect. Software must read the ports first, which ends the mismatch, and then clear the flag. At reset the reference is loaded from the pins, so leaving reset never raises a false flag.

Top module: `ioc_detector`

## Requirements
- R1: For as long as reset is held, the pin enables clear to 0, the flag clears to 0 and the reference loads from the synchronized pins. After reset the flag stays 0 while the pins do not move, even once every pin is enabled.
- R2: A change on an enabled port A pin raises `chg_flag` on the third rising clock edge after the change: two synchronizer edges and one flag edge. The flag is still 0 after the second edge.
- R3: `pb_pin[k]` is port B pin 4+k. A change on an enabled port B pin sets the flag with the same latency as port A.
- R4: A pin whose enable bit is 0 never sets the flag, whatever it does.
- R5: The flag sets whatever the value of `chg_ie`. `chg_irq` is 1 only while both `chg_flag` and `chg_ie` are 1.
- R6: While an enabled pin still differs from its reference, a `flag_clr` pulse leaves `chg_flag` at 1, because setting wins over clearing.
- R7: A `port_rd` pulse loads the reference from the synchronized pins. After that read, or in the same cycle as it, a `flag_clr` pulse clears the flag.
- R8: A pin change that reaches the synchronizer output on the same edge that a read captures is compared against the new reference on the next cycle, so it still sets the flag.
- R9: `pa_data`/`pb_data` show the pin levels two rising edges after the pins change, including the levels of disabled pins.
- R10: A write to a pin-enable register takes effect on the next edge. A mismatch that was pending on a newly enabled pin sets the flag one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pa_pin | input | 6 | Port A pins 5..0, asynchronous |
| pb_pin | input | 4 | Port B pins 7..4, asynchronous |
| pa_en_we | input | 1 | Write strobe for the port A pin-enable register |
| pa_en_wd | input | 6 | New port A pin enables |
| pb_en_we | input | 1 | Write strobe for the port B pin-enable register |
| pb_en_wd | input | 4 | New port B pin enables |
| port_rd | input | 1 | Port read strobe; loads the reference |
| flag_clr | input | 1 | Software clear of the change flag |
| chg_ie | input | 1 | Port-change interrupt enable |
| pa_data | output | 6 | Synchronized port A levels |
| pb_data | output | 4 | Synchronized port B levels |
| chg_flag | output | 1 | Sticky change flag |
| chg_irq | output | 1 | Flag gated by `chg_ie` |

## Verification
The assertions assume that `port_rd`, `flag_clr` and the enable write strobes are synchronous single-cycle pulses. They also assume the pins are held steady through reset, since the reference copies them only while reset is low. The bench drives every input just after a falling edge and holds the pins steady across reset. It moves a pin only at a falling edge, so each change reaches the comparator at a known rising edge. That known timing is what lets the same-edge read case be hit exactly.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
   // Default geometry of the monitored pin set
   localparam int unsigned PA_PINS    = 6;
   localparam int unsigned PB_PINS    = 4;
   localparam int unsigned PB_LSB     = 4;
   localparam int unsigned SYNC_DEPTH = 2;

   // Reduce a per-pin mismatch vector to a single hit
   function automatic logic any_set(input logic [31:0] v);
      return |v;
   endfunction
endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
   parameter int unsigned W      = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("ioc_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("ioc_sync: W must be at least 1");
   end

   // Shift chain; no reset so the reference can copy live pins during reset
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk) begin
      stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/ioc_port_cmp.sv
module ioc_port_cmp #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_we,
   input  logic [W-1:0] en_wd,
   input  logic         rd,
   input  logic [W-1:0] live,
   output logic [W-1:0] ref_q,
   output logic         hit
);
   if (W < 1 || W > 32) begin : g_bad_width
      $error("ioc_port_cmp: W must be 1..32");
   end

   logic [W-1:0] en_q;
   logic [W-1:0] cmp_ref;
   logic [W-1:0] diff;

   // Pin enables and reference copy
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= '0;
         ref_q <= live;
      end else begin
         if (en_we) en_q  <= en_wd;
         if (rd)    ref_q <= live;
      end
   end

   // A read cycle compares against the value being captured
   assign cmp_ref = rd ? live : ref_q;

   for (genvar i = 0; i < W; i++) begin : g_pin
      assign diff[i] = en_q[i] & (live[i] ^ cmp_ref[i]);
   end

   assign hit = ioc_pkg::any_set(32'(diff));

   // R7
   relatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> (ref_q == $past(live)));

   // R10
   en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_we |=> (en_q == $past(en_wd)));

   // R7
   ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd && $past(rst_n)) |=> $stable(ref_q));
endmodule

// File: rtl/ioc_flag.sv
module ioc_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic clr,
   output logic flag
);
   // Set has priority over clear
   always_ff @(posedge clk) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= hit | (flag & ~clr);
   end

   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);

   // R7
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hit) |=> !flag);

   // R4
   rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(hit));
endmodule

// File: rtl/ioc_detector.sv
module ioc_detector #(
   parameter int unsigned PA_W   = ioc_pkg::PA_PINS,
   parameter int unsigned PB_W   = ioc_pkg::PB_PINS,
   parameter int unsigned SYNC_N = ioc_pkg::SYNC_DEPTH
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PA_W-1:0] pa_pin,
   input  logic [PB_W-1:0] pb_pin,
   input  logic            pa_en_we,
   input  logic [PA_W-1:0] pa_en_wd,
   input  logic            pb_en_we,
   input  logic [PB_W-1:0] pb_en_wd,
   input  logic            port_rd,
   input  logic            flag_clr,
   input  logic            chg_ie,
   output logic [PA_W-1:0] pa_data,
   output logic [PB_W-1:0] pb_data,
   output logic            chg_flag,
   output logic            chg_irq
);
   localparam int unsigned TOTAL_W = PA_W + PB_W;

   if (TOTAL_W > 32) begin : g_bad_total
      $error("ioc_detector: too many monitored pins");
   end

   logic [PA_W-1:0] pa_sync, pa_ref;
   logic [PB_W-1:0] pb_sync, pb_ref;
   logic            pa_hit, pb_hit;

   ioc_sync #(.W(PA_W), .STAGES(SYNC_N)) u_sync_a (
      .clk (clk), .d (pa_pin), .q (pa_sync)
   );
   ioc_sync #(.W(PB_W), .STAGES(SYNC_N)) u_sync_b (
      .clk (clk), .d (pb_pin), .q (pb_sync)
   );

   ioc_port_cmp #(.W(PA_W)) u_cmp_a (
      .clk (clk), .rst_n (rst_n), .en_we (pa_en_we), .en_wd (pa_en_wd),
      .rd (port_rd), .live (pa_sync), .ref_q (pa_ref), .hit (pa_hit)
   );
   ioc_port_cmp #(.W(PB_W)) u_cmp_b (
      .clk (clk), .rst_n (rst_n), .en_we (pb_en_we), .en_wd (pb_en_wd),
      .rd (port_rd), .live (pb_sync), .ref_q (pb_ref), .hit (pb_hit)
   );

   ioc_flag u_flag (
      .clk (clk), .rst_n (rst_n), .hit (pa_hit | pb_hit),
      .clr (flag_clr), .flag (chg_flag)
   );

   assign pa_data = pa_sync;
   assign pb_data = pb_sync;
   assign chg_irq = chg_flag & chg_ie;

   // R5
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_flag && !chg_ie) |-> !chg_irq);

   // R7
   read_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_rd |=> (pa_ref == $past(pa_data)) && (pb_ref == $past(pb_data)));
endmodule

// File: tb/ioc_detector_test.sv
`timescale 1ns/1ps
module ioc_detector_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] pa_pin = 6'h2A;
   logic [3:0] pb_pin = 4'h5;
   logic       pa_en_we = 1'b0, pb_en_we = 1'b0;
   logic [5:0] pa_en_wd = '0;
   logic [3:0] pb_en_wd = '0;
   logic       port_rd = 1'b0, flag_clr = 1'b0, chg_ie = 1'b0;
   logic [5:0] pa_data;
   logic [3:0] pb_data;
   logic       chg_flag, chg_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ioc_detector uut (
      .clk (clk), .rst_n (rst_n), .pa_pin (pa_pin), .pb_pin (pb_pin),
      .pa_en_we (pa_en_we), .pa_en_wd (pa_en_wd),
      .pb_en_we (pb_en_we), .pb_en_wd (pb_en_wd),
      .port_rd (port_rd), .flag_clr (flag_clr), .chg_ie (chg_ie),
      .pa_data (pa_data), .pb_data (pb_data),
      .chg_flag (chg_flag), .chg_irq (chg_irq)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_rd_clr(input bit rd, input bit clr);
      port_rd = rd; flag_clr = clr;
      step(1);
      port_rd = 1'b0; flag_clr = 1'b0;
   endtask

   task automatic flush();
      pulse_rd_clr(1'b1, 1'b0);
      pulse_rd_clr(1'b0, 1'b1);
   endtask

   task automatic t_reset();
      step(5);
      rst_n = 1'b1;
      check("R1 flag after reset", chg_flag, 0);
      pa_en_we = 1'b1; pa_en_wd = 6'h3F; pb_en_we = 1'b1; pb_en_wd = 4'hF;
      step(1);
      pa_en_we = 1'b0; pb_en_we = 1'b0;
      step(4);
      check("R1 no spurious flag", chg_flag, 0);
      check("R9 pa_data reset levels", pa_data, 6'h2A);
      check("R9 pb_data reset levels", pb_data, 4'h5);
   endtask

   task automatic t_port_a();
      pa_pin[0] = ~pa_pin[0];
      step(1);
      check("R9 pa_data not yet", pa_data, 6'h2A);
      step(1);
      check("R2 flag not before third edge", chg_flag, 0);
      check("R9 pa_data after two edges", pa_data, 6'h2B);
      step(1);
      check("R2 flag set", chg_flag, 1);
      check("R5 irq masked", chg_irq, 0);
      chg_ie = 1'b1; #1;
      check("R5 irq enabled", chg_irq, 1);
      chg_ie = 1'b0;
      pulse_rd_clr(1'b1, 1'b0);
      check("R7 flag holds over read", chg_flag, 1);
      pulse_rd_clr(1'b0, 1'b1);
      check("R7 clear after read", chg_flag, 0);
   endtask

   task automatic t_persist();
      pa_pin[1] = ~pa_pin[1];
      step(3);
      check("R6 flag set", chg_flag, 1);
      pulse_rd_clr(1'b0, 1'b1);
      check("R6 clear ignored", chg_flag, 1);
      step(2);
      check("R6 still set", chg_flag, 1);
      pulse_rd_clr(1'b1, 1'b1);
      check("R7 read and clear same cycle", chg_flag, 0);
   endtask

   task automatic t_disabled();
      pa_en_we = 1'b1; pa_en_wd = 6'h3E;
      step(1);
      pa_en_we = 1'b0;
      pa_pin[0] = ~pa_pin[0];
      step(4);
      check("R4 disabled pin no flag", chg_flag, 0);
      check("R9 disabled pin visible", pa_data[0], pa_pin[0]);
      pa_en_we = 1'b1; pa_en_wd = 6'h3F;
      step(1);
      pa_en_we = 1'b0;
      check("R10 flag not yet", chg_flag, 0);
      step(1);
      check("R10 pending mismatch flags", chg_flag, 1);
      flush();
      check("R7 flush", chg_flag, 0);
   endtask

   task automatic t_port_b();
      pb_pin[3] = ~pb_pin[3];
      step(2);
      check("R3 flag not before third edge", chg_flag, 0);
      check("R3 pb_data pin 7", pb_data, 4'hD);
      step(1);
      check("R3 port B flag", chg_flag, 1);
      flush();
      check("R3 flush", chg_flag, 0);
   endtask

   task automatic t_same_edge();
      pb_pin[0] = ~pb_pin[0];
      step(1);
      pulse_rd_clr(1'b1, 1'b0);
      check("R8 no flag on read edge", chg_flag, 0);
      step(1);
      check("R8 change not lost", chg_flag, 1);
      flush();
      step(3);
      check("R8 quiet after flush", chg_flag, 0);
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_port_a();
      t_persist();
      t_disabled();
      t_port_b();
      t_same_edge();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule